// File: doc/BRIEF.md
# Single-Pin Dual Reset Discriminator

This block sits on the CPU side of a shared, active-low reset pin. It resolves each assertion of the pin into one of two kinds of reset. A full reset is used to disable maskable interrupts, select interrupt mode 0 and clear the I, R and program-counter registers. A program-counter-only reset leaves every other piece of machine state untouched, so a debug monitor can take over at address zero while the interrupted program's context is kept.

The kind is chosen by when the pin is seen low, measured against the opcode-fetch T-states. The sequencer supplies two decoded indicators. `fetchCycle` is high during T1 and T2 of a fetch. `fetchT2` is high during T2 of a fetch. Both change just after a rising clock edge and stay valid for the whole T-state.

The pin is captured on rising edges. The captured value is then moved to either the full-reset flag or the PC-clear flag on falling edges, and the edge chosen depends on the T-state. A pin that is low only at the rising edge that opens fetch T2 gives a PC-only reset. A pin that is low at any other rising edge, or at two rising edges in a row, gives a full reset. A one-clock strobe then tells the register file to load zero into the program counter during T2 of the next fetch.

Top module: `dual_reset_discriminator`

## Requirements
- R1: When the pin is low at a rising edge, `fullReset` is high after the next falling edge, unless that falling edge lies in fetch T2 (`fetchCycle`=1, `fetchT2`=1). In that case `fullReset` rises at the following falling edge, provided the pin is still low at the rising edge before it.
- R2: `fullReset` stays high while the pin keeps being sampled low. It falls at the first falling edge outside fetch T2 after a rising edge that sampled the pin high, so a release that falls due inside T2 is held back by one T-state.
- R3: If the pin is low only at the rising edge that starts fetch T2, `pcClear` goes high at the falling edge of that T2 and `fullReset` stays low.
- R4: If the pin is low at the rising edges that start both fetch T1 and fetch T2, the reset is full and `pcClear` never goes high.
- R5: If the pin is low at the rising edges that start fetch T2 and T3, `pcClear` goes high in T2 and is cleared at the falling edge of T3, when `fullReset` rises.
- R6: Once set, and with no full reset, `pcClear` holds until the falling edge of T2 in the next fetch. At that edge it reloads the value captured at the start of that T2.
- R7: `pcZero` is high for exactly the one T-state that follows a rising edge ending fetch T1 (`fetchCycle`=1, `fetchT2`=0) at which `pcClear` was high. In every other T-state it is low.
- R8: `fullReset` clears `pcClear` asynchronously, and this clear wins over a T2 capture at the same moment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; the pin is captured on the rising edge, and the decisions are made on the falling edge |
| rstPinN | input | 1 | Shared reset pin, active low |
| fetchCycle | input | 1 | High during T1 and T2 of an opcode fetch |
| fetchT2 | input | 1 | High during T2 of an opcode fetch |
| fullReset | output | 1 | Full-reset level (interrupts off, mode 0, I/R/PC cleared) |
| pcClear | output | 1 | PC-only reset pending |
| pcZero | output | 1 | One-T-state strobe telling the program counter to load zero |

## Verification
The hardest cases to reach are the ones where the pin is low at two adjacent rising edges that straddle fetch T2. These are the pairs T1/T2 and T2/T3. In them, the T2 capture and the asynchronous full-reset clear fall on neighbouring edges, and the outcome depends on exact alignment with the T-state indicators. Directed sequences place short pulses on each of these edges, and on a lone T2 edge, then follow the PC-only case through the next fetch to the zero strobe. A long random run of fetch and non-fetch machine cycles with sparse pin pulses is checked against a cycle model, which covers pulses of every length at every phase.

// File: rtl/dual_reset_pkg.sv
package dual_reset_pkg;

  // Per-T-state sampling windows handed from phase control to the sampler
  typedef struct packed {
    logic normalWin;   // falling edge may update the full-reset flag
    logic specialWin;  // falling edge may update the PC-clear flag
    logic zeroWin;     // rising edge closing fetch T1
  } sample_strobes_t;

endpackage

// File: rtl/rst_phase_ctrl.sv
module rst_phase_ctrl
  import dual_reset_pkg::*;
(
  input  logic            fetchCycle,
  input  logic            fetchT2,
  output sample_strobes_t strobes
);

  logic inT1;
  logic inT2;

  assign inT1 = fetchCycle & ~fetchT2;
  assign inT2 = fetchCycle & fetchT2;

  always_comb begin
    strobes.normalWin  = ~inT2;
    strobes.specialWin = inT2;
    strobes.zeroWin    = inT1;
  end

endmodule

// File: rtl/rst_sample_dp.sv
module rst_sample_dp
  import dual_reset_pkg::*;
(
  input  logic            clk,
  input  logic            rstPinN,
  input  sample_strobes_t strobes,
  output logic            fullReset,
  output logic            pcClear,
  output logic            pcZero
);

  logic resetReq;

  // Pin capture on every rising edge
  always_ff @(posedge clk) begin
    resetReq <= ~rstPinN;
  end

  // Full-reset flag: every falling edge except in fetch T2
  always_ff @(negedge clk) begin
    if (strobes.normalWin) fullReset <= resetReq;
  end

  // PC-clear flag: falling edge of fetch T2 only, cleared by full reset
  always_ff @(negedge clk or posedge fullReset) begin
    if (fullReset)               pcClear <= 1'b0;
    else if (strobes.specialWin) pcClear <= resetReq;
  end

  // Zero strobe launched at the edge that opens fetch T2
  always_ff @(posedge clk) begin
    pcZero <= pcClear & strobes.zeroWin;
  end

  // R1: a captured request outside T2 becomes a full reset
  assert_req_to_full_R1: assert property (@(negedge clk) disable iff (1'b0)
    (resetReq && strobes.normalWin) |=> fullReset);

  // R3: a captured request at T2 with no full reset sets the PC clear
  assert_special_capture_R3: assert property (@(negedge clk) disable iff (fullReset)
    (resetReq && strobes.specialWin) |=> pcClear);

  // R6: outside T2 the PC clear only moves by the full-reset clear
  assert_clear_hold_R6: assert property (@(negedge clk) disable iff (fullReset)
    !strobes.specialWin |=> $stable(pcClear));

  // R7: strobe follows a pending clear at the end of T1, and nothing else
  assert_zero_strobe_R7: assert property (@(posedge clk) disable iff (fullReset)
    (pcClear && strobes.zeroWin) |=> pcZero);
  assert_zero_quiet_R7: assert property (@(posedge clk) disable iff (fullReset)
    !(pcClear && strobes.zeroWin) |=> !pcZero);

  // R8: a full reset never coexists with a pending PC clear
  always_ff @(posedge clk) begin
    if (fullReset) assert_full_wins_R8: assert (!pcClear);
  end

endmodule

// File: rtl/dual_reset_discriminator.sv
module dual_reset_discriminator
  import dual_reset_pkg::*;
(
  input  logic clk,
  input  logic rstPinN,
  input  logic fetchCycle,
  input  logic fetchT2,
  output logic fullReset,
  output logic pcClear,
  output logic pcZero
);

  sample_strobes_t strobes;

  rst_phase_ctrl u_ctrl (
    .fetchCycle (fetchCycle),
    .fetchT2    (fetchT2),
    .strobes    (strobes)
  );

  rst_sample_dp u_dp (
    .clk       (clk),
    .rstPinN   (rstPinN),
    .strobes   (strobes),
    .fullReset (fullReset),
    .pcClear   (pcClear),
    .pcZero    (pcZero)
  );

endmodule

// File: tb/dual_reset_discriminator_test.sv
module dual_reset_discriminator_test;

  localparam int PH_OTH = 0;
  localparam int PH_T1  = 1;
  localparam int PH_T2  = 2;

  logic clk = 1'b0;
  logic rstPinN = 1'b0;
  logic fetchCycle = 1'b0;
  logic fetchT2 = 1'b0;
  logic fullReset, pcClear, pcZero;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // cycle model state
  bit mResi = 1, mNres = 1, mClr = 0, mPcz = 0;
  bit prevPin = 0;
  int prevPh = PH_OTH;

  always #2.5 clk = ~clk;

  dual_reset_discriminator uut (
    .clk(clk), .rstPinN(rstPinN), .fetchCycle(fetchCycle), .fetchT2(fetchT2),
    .fullReset(fullReset), .pcClear(pcClear), .pcZero(pcZero)
  );

  function automatic bit phIsT1(int ph); return ph == PH_T1; endfunction

  task automatic check(bit ok, string tag, bit act, bit exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One T-state: drive pin/phase after the rising edge, update model, compare
  task automatic step(bit pin, int ph, bit cmp);
    @(posedge clk);
    mPcz  = mClr && phIsT1(prevPh);
    mResi = !prevPin;
    #1;
    rstPinN    = pin;
    fetchCycle = (ph != PH_OTH);
    fetchT2    = (ph == PH_T2);
    @(negedge clk);
    if (ph != PH_T2) mNres = mResi;
    if (mNres) mClr = 0;
    else if (ph == PH_T2) mClr = mResi;
    #1;
    if (cmp) begin
      check(fullReset == mNres, "R2 fullReset model", fullReset, mNres);
      check(pcClear == mClr, "R6 pcClear model", pcClear, mClr);
      check(pcZero == mPcz, "R7 pcZero model", pcZero, mPcz);
    end
    prevPin = pin;
    prevPh  = ph;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, PH_OTH, 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ph;
    bit pin;
    void'($urandom(32'd1258));
    // reset state with pin held low
    step(0, PH_OTH, 0); step(0, PH_OTH, 0); step(0, PH_OTH, 1);
    check(fullReset == 1, "R1 reset state fullReset", fullReset, 1);
    check(pcClear == 0, "R8 reset state pcClear", pcClear, 0);
    check(pcZero == 0, "R7 reset state pcZero", pcZero, 0);
    idle(3);
    check(fullReset == 0, "R2 release", fullReset, 0);

    // R1: single-edge pulse outside fetch gives a full reset
    step(0, PH_OTH, 1); step(1, PH_OTH, 1);
    check(fullReset == 1, "R1 single edge", fullReset, 1);
    step(1, PH_OTH, 1);
    check(fullReset == 0, "R2 drop after one", fullReset, 0);

    // R3/R6/R7: lone T2-edge pulse gives PC-only reset
    idle(2);
    step(0, PH_T1, 1); step(1, PH_T2, 1);
    check(pcClear == 1, "R3 pcClear set", pcClear, 1);
    check(fullReset == 0, "R3 no full reset", fullReset, 0);
    step(1, PH_OTH, 1); step(1, PH_OTH, 1);
    check(pcClear == 1, "R6 hold to next fetch", pcClear, 1);
    step(1, PH_T1, 1);
    check(pcZero == 0, "R7 quiet in T1", pcZero, 0);
    step(1, PH_T2, 1);
    check(pcZero == 1, "R7 strobe in T2", pcZero, 1);
    check(pcClear == 0, "R6 reload at T2", pcClear, 0);
    step(1, PH_OTH, 1);
    check(pcZero == 0, "R7 strobe one state", pcZero, 0);
    idle(2);

    // R4: low at T1 and T2 starting edges
    step(0, PH_OTH, 1); step(0, PH_T1, 1);
    check(pcClear == 0, "R4 no clear in T1", pcClear, 0);
    step(1, PH_T2, 1);
    check(fullReset == 1, "R4 full", fullReset, 1);
    check(pcClear == 0, "R4 no clear in T2", pcClear, 0);
    step(1, PH_OTH, 1);
    check(fullReset == 0, "R2 release after T2", fullReset, 0);
    idle(2);

    // R2: release deferred across T2
    step(0, PH_OTH, 1); step(1, PH_T1, 1); step(1, PH_T2, 1);
    check(fullReset == 1, "R2 held through T2", fullReset, 1);
    step(1, PH_OTH, 1);
    check(fullReset == 0, "R2 released after T2", fullReset, 0);
    idle(2);

    // R5/R8: low at T2 and T3 starting edges
    step(0, PH_T1, 1); step(0, PH_T2, 1);
    check(pcClear == 1, "R5 set in T2", pcClear, 1);
    step(1, PH_OTH, 1);
    check(fullReset == 1, "R5 full in T3", fullReset, 1);
    check(pcClear == 0, "R8 cleared in T3", pcClear, 0);
    step(1, PH_OTH, 1);
    check(fullReset == 0, "R2 release T4", fullReset, 0);
    idle(2);

    // R8: pending clear wiped by a later full reset outside fetch
    step(0, PH_T1, 1); step(1, PH_T2, 1); step(0, PH_OTH, 1); step(1, PH_OTH, 1);
    check(pcClear == 0, "R8 late full reset", pcClear, 0);
    step(1, PH_T1, 1); step(1, PH_T2, 1);
    check(pcZero == 0, "R7 no strobe after R8", pcZero, 0);
    idle(3);

    // random machine cycles with sparse pulses
    for (int c = 0; c < 1500; c++) begin
      bit isFetch = ($urandom % 3) != 0;
      for (int t = 0; t < (isFetch ? 4 : 3); t++) begin
        ph = !isFetch ? PH_OTH : (t == 0 ? PH_T1 : (t == 1 ? PH_T2 : PH_OTH));
        pin = ($urandom % 8) != 0;
        step(pin, ph, 1);
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule